// File: doc/BRIEF.md
# Externally Clocked Serial Byte Link Engine

This block receives and transmits bytes over a two-wire serial link whose clock comes from the remote side. Both wires are open-collector and idle high. Each frame has a low start bit, eight data bits and one parity slot. The engine does all of its work on falling edges of the remote clock. It first brings both wires into the system clock domain, and it finds the falling edge from the synchronised samples. Each received byte is placed in a receive FIFO. The first bit on the wire becomes the most significant bit of the stored byte.

Transmission uses the same frames. When a start bit arrives, the engine takes the oldest byte from a transmit FIFO. It then shifts that byte out, MSB first, on a separate output pin, one bit per data-bit edge. When the transmit FIFO is empty, the engine sends all ones. The byte leaves the transmit FIFO only at the parity slot, and only when a real byte was taken. A processor-side port pops received bytes and pushes bytes for transmission. Each access is answered one cycle later with a byte and a "nothing" flag.

Top module: `sr_link_engine`

## Requirements
- R1: After reset the transmit pin is high, and both FIFOs are empty.
- R2: A frame starts only on a falling edge of the serial clock while the data wire is low. A falling edge with data high leaves the engine waiting, and the byte that follows is received unshifted.
- R3: The eight data bits are shifted in so that the first bit on the wire ends up in bit 7 of the stored byte and the last bit in bit 0.
- R4: The value sampled in the parity slot has no effect on the stored byte. The byte is in the receive FIFO once the parity falling edge has been processed, before the clock rises again.
- R5: On each data-bit falling edge, the transmit pin takes the next bit of the loaded transmit byte, MSB first. The pin changes at no other time.
- R6: When the transmit FIFO is empty at the start bit, the frame transmits 0xFF.
- R7: A transmitted byte is removed from the transmit FIFO at the parity slot of its frame, and only if it was actually loaded, so every written byte is sent exactly once and in order.
- R8: A processor read returns the oldest received byte with the nothing flag low. On an empty receive FIFO it returns 0x00 with the nothing flag high.
- R9: The transmit FIFO accepts 255 bytes. A write that finds it full is dropped and is answered with 0x00 and the full flag high. An accepted write echoes its byte with the flag low.
- R10: The receive FIFO holds 255 bytes. A frame that completes while the FIFO is full is discarded, and the stored bytes stay intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Remote serial clock wire (idle high) |
| ser_dat_i | input | 1 | Remote serial data wire (idle high) |
| ser_tx_o | output | 1 | Transmit data pin, clocked by the remote clock |
| rd_req_i | input | 1 | Processor read request (pops the receive FIFO) |
| rd_valid_o | output | 1 | Read answer valid, one cycle after the request |
| rd_data_o | output | 8 | Received byte, or 0x00 when none |
| rd_none_o | output | 1 | High when the read found the receive FIFO empty |
| wr_req_i | input | 1 | Processor write request (pushes the transmit FIFO) |
| wr_data_i | input | 8 | Byte to transmit |
| wr_valid_o | output | 1 | Write answer valid, one cycle after the request |
| wr_ret_o | output | 8 | Echo of the written byte, or 0x00 when dropped |
| wr_full_o | output | 1 | High when the write found the transmit FIFO full |

## Verification
A change on either serial wire takes three system clock edges to act: two synchroniser stages, then the registered frame step. The FIFO pointers and the transmit pin are updated on that third edge. The bench therefore holds each serial level for five cycles and samples the transmit pin and the receive FIFO only after that settling time. Processor answers are registered once, so the bench raises a request for one cycle and reads the answer at the next falling system clock edge. The parity-commit check reads the FIFO while the serial clock is still low.

// File: rtl/sr_link_pkg.sv
package sr_link_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

    typedef enum logic [1:0] {
        FR_WAIT   = 2'd0,
        FR_DATA   = 2'd1,
        FR_PARITY = 2'd2
    } frame_st_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              flag;
    } cpu_rsp_t;

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] r,
                                                    input logic b);
        return {r[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/sr_line_sync.sv
module sr_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        end
        assign lvl_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sr_fall_detect.sv
module sr_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_q;
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl_i;
    end
    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/sr_byte_fifo.sv
module sr_byte_fifo #(
    parameter int unsigned DEPTH = 255,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CAP);
    assign do_push = push_i & ~full_o;
    assign do_pop  = pop_i & ~empty_o;
    assign head_o  = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i) |=> ($stable(count_q) && $stable(wr_ptr_q))); // R10

endmodule

// File: rtl/sr_frame_fsm.sv
module sr_frame_fsm
    import sr_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              dat_i,
    input  logic              tx_empty_i,
    input  logic [BYTE_W-1:0] tx_head_i,
    output logic              rx_push_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              tx_pop_o,
    output logic              tx_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    frame_st_e         st_q;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic              taken_q;
    logic              tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FR_WAIT;
            bit_q   <= '0;
            rx_sh_q <= '0;
            tx_sh_q <= FILL_BYTE;
            taken_q <= 1'b0;
            tx_q    <= 1'b1;
        end else if (fall_i) begin
            unique case (st_q)
                FR_WAIT: begin
                    if (!dat_i) begin
                        st_q    <= FR_DATA;
                        bit_q   <= '0;
                        taken_q <= ~tx_empty_i;
                        tx_sh_q <= tx_empty_i ? FILL_BYTE : tx_head_i;
                    end
                end
                FR_DATA: begin
                    rx_sh_q <= shift_in(rx_sh_q, dat_i);
                    tx_q    <= tx_sh_q[BYTE_W-1];
                    tx_sh_q <= shift_in(tx_sh_q, 1'b1);
                    bit_q   <= bit_q + 1'b1;
                    if (bit_q == LAST_BIT) st_q <= FR_PARITY;
                end
                FR_PARITY: begin
                    st_q <= FR_WAIT;
                end
                default: st_q <= FR_WAIT;
            endcase
        end
    end

    assign rx_push_o = fall_i && (st_q == FR_PARITY);
    assign rx_byte_o = rx_sh_q;
    assign tx_pop_o  = rx_push_o && taken_q;
    assign tx_o      = tx_q;

    AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_WAIT && !(fall_i && !dat_i)) |=> (st_q == FR_WAIT)); // R2

    AST_TX_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_q) |-> $past(fall_i)); // R5

    AST_POP_ONLY_FILLED: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |-> !tx_empty_i); // R7

endmodule

// File: rtl/sr_link_engine.sv
module sr_link_engine
    import sr_link_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 255,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    output logic              ser_tx_o,
    input  logic              rd_req_i,
    output logic              rd_valid_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_none_o,
    input  logic              wr_req_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_ret_o,
    output logic              wr_full_o
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] lvl;
    logic               sclk_fall;
    logic               rx_push, rx_empty, rx_full;
    logic [BYTE_W-1:0]  rx_byte, rx_head;
    logic               tx_pop, tx_empty, tx_full;
    logic [BYTE_W-1:0]  tx_head;
    cpu_rsp_t           rd_rsp_q, wr_rsp_q;

    sr_line_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i ({ser_dat_i, ser_clk_i}),
        .lvl_o (lvl)
    );

    sr_fall_detect u_fall (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl[0]),
        .fall_o (sclk_fall)
    );

    sr_frame_fsm u_frame (
        .clk        (clk),
        .rst        (rst),
        .fall_i     (sclk_fall),
        .dat_i      (lvl[1]),
        .tx_empty_i (tx_empty),
        .tx_head_i  (tx_head),
        .rx_push_o  (rx_push),
        .rx_byte_o  (rx_byte),
        .tx_pop_o   (tx_pop),
        .tx_o       (ser_tx_o)
    );

    sr_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (rx_push),
        .din_i   (rx_byte),
        .pop_i   (rd_req_i),
        .head_o  (rx_head),
        .empty_o (rx_empty),
        .full_o  (rx_full)
    );

    sr_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (wr_req_i),
        .din_i   (wr_data_i),
        .pop_i   (tx_pop),
        .head_o  (tx_head),
        .empty_o (tx_empty),
        .full_o  (tx_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_rsp_q <= '0;
            wr_rsp_q <= '0;
        end else begin
            rd_rsp_q.valid <= rd_req_i;
            rd_rsp_q.data  <= rx_empty ? '0 : rx_head;
            rd_rsp_q.flag  <= rx_empty;
            wr_rsp_q.valid <= wr_req_i;
            wr_rsp_q.data  <= tx_full ? '0 : wr_data_i;
            wr_rsp_q.flag  <= tx_full;
        end
    end

    assign rd_valid_o = rd_rsp_q.valid;
    assign rd_data_o  = rd_rsp_q.data;
    assign rd_none_o  = rd_rsp_q.flag;
    assign wr_valid_o = wr_rsp_q.valid;
    assign wr_ret_o   = wr_rsp_q.data;
    assign wr_full_o  = wr_rsp_q.flag;

    AST_RD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && rx_empty) |=> (rd_none_o && rd_data_o == '0)); // R8

    AST_WR_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && tx_full) |=> (wr_full_o && wr_ret_o == '0)); // R9

    AST_RX_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_push && !rd_req_i) |=> rx_full); // R10

endmodule

// File: tb/sr_link_engine_tb.sv
module sr_link_engine_tb;

    localparam int HOLD = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b1;
    logic       ser_dat = 1'b1;
    logic       ser_tx;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_none;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_valid;
    logic [7:0] wr_ret;
    logic       wr_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sr_link_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (ser_clk),
        .ser_dat_i  (ser_dat),
        .ser_tx_o   (ser_tx),
        .rd_req_i   (rd_req),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data),
        .rd_none_o  (rd_none),
        .wr_req_i   (wr_req),
        .wr_data_i  (wr_data),
        .wr_valid_o (wr_valid),
        .wr_ret_o   (wr_ret),
        .wr_full_o  (wr_full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_read(output logic [7:0] d, output logic none);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        check("R8 rd_valid", rd_valid, 1'b1);
        d = rd_data;
        none = rd_none;
    endtask

    task automatic cpu_write(input logic [7:0] v, output logic [7:0] ret, output logic full);
        @(negedge clk) begin wr_req = 1'b1; wr_data = v; end
        @(negedge clk) wr_req = 1'b0;
        check("R9 wr_valid", wr_valid, 1'b1);
        ret = wr_ret;
        full = wr_full;
    endtask

    // One falling/rising pulse of the serial clock with a given data level.
    task automatic ser_bit(input logic b);
        @(negedge clk) ser_dat = b;
        idle(HOLD);
        ser_clk = 1'b0;
        idle(HOLD);
        ser_clk = 1'b1;
        idle(HOLD);
    endtask

    // Full frame; value v is sent so that it is stored as v. Captures ser_tx per data bit.
    task automatic send_frame(input logic [7:0] v, input logic par,
                              input bit peek, output logic [7:0] cap);
        logic [7:0] d;
        logic       none;
        ser_bit(1'b0);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) ser_dat = v[i];
            idle(HOLD);
            ser_clk = 1'b0;
            idle(HOLD);
            cap[i] = ser_tx;
            ser_clk = 1'b1;
            idle(HOLD);
        end
        @(negedge clk) ser_dat = par;
        idle(HOLD);
        ser_clk = 1'b0;
        idle(HOLD);
        if (peek) begin
            cpu_read(d, none);
            check("R4 committed before clock rises", {23'd0, none, d}, {23'd0, 1'b0, v});
        end
        ser_clk = 1'b1;
        ser_dat = 1'b1;
        idle(HOLD);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic       none;
        check("R1 tx pin high", ser_tx, 1'b1);
        cpu_read(d, none);
        check("R1 rx empty flag", none, 1'b1);
        check("R8 empty read data", d, 8'h00);
    endtask

    task automatic t_start_and_order;
        logic [7:0] d, cap;
        logic       none;
        ser_bit(1'b1);                      // falling edge with data high: no start
        send_frame(8'hA5, 1'b0, 1'b0, cap);
        check("R6 idle tx sends FF", cap, 8'hFF);
        cpu_read(d, none);
        check("R2 byte after high-data edge", d, 8'hA5);
        send_frame(8'h80, 1'b1, 1'b0, cap);
        send_frame(8'h01, 1'b0, 1'b0, cap);
        cpu_read(d, none);
        check("R3 first bit lands in bit 7", d, 8'h80);
        cpu_read(d, none);
        check("R3 last bit lands in bit 0", d, 8'h01);
        check("R8 non-empty flag low", none, 1'b0);
        cpu_read(d, none);
        check("R8 empty after drain", none, 1'b1);
    endtask

    task automatic t_parity;
        logic [7:0] d, cap;
        logic       none;
        send_frame(8'h3C, 1'b0, 1'b1, cap);
        send_frame(8'h3C, 1'b1, 1'b0, cap);
        cpu_read(d, none);
        check("R4 parity one ignored", {23'd0, none, d}, {23'd0, 1'b0, 8'h3C});
    endtask

    task automatic t_tx;
        logic [7:0] ret, cap, d;
        logic       full, none;
        cpu_write(8'h5A, ret, full);
        check("R9 accepted echo", ret, 8'h5A);
        cpu_write(8'hC3, ret, full);
        check("R9 accepted flag", full, 1'b0);
        send_frame(8'h11, 1'b0, 1'b0, cap);
        check("R5 first tx byte", cap, 8'h5A);
        send_frame(8'h22, 1'b0, 1'b0, cap);
        check("R7 second tx byte", cap, 8'hC3);
        send_frame(8'h33, 1'b0, 1'b0, cap);
        check("R6 FF after drain", cap, 8'hFF);
        send_frame(8'h44, 1'b0, 1'b0, cap);
        check("R7 no pop on empty", cap, 8'hFF);
        for (int i = 0; i < 4; i++) cpu_read(d, none);
        cpu_read(d, none);
        check("R8 rx drained", none, 1'b1);
    endtask

    task automatic t_capacity;
        logic [7:0] ret, cap, d;
        logic       full, none;
        for (int i = 0; i < 255; i++) begin
            cpu_write(8'(i), ret, full);
            if (full || ret != 8'(i)) check("R9 write within capacity", {23'd0, full, ret}, {23'd0, 1'b0, 8'(i)});
        end
        cpu_write(8'hEE, ret, full);
        check("R9 write on full flag", full, 1'b1);
        check("R9 write on full data", ret, 8'h00);
        for (int i = 0; i < 256; i++) begin
            send_frame(8'(i) ^ 8'h55, 1'b0, 1'b0, cap);
            if (i < 255 && cap != 8'(i)) check("R7 tx order", cap, 8'(i));
            if (i == 255) check("R6 FF after full drain", cap, 8'hFF);
        end
        for (int i = 0; i < 255; i++) begin
            cpu_read(d, none);
            if (none || d != (8'(i) ^ 8'h55)) check("R10 rx content kept", {23'd0, none, d}, {23'd0, 1'b0, 8'(i) ^ 8'h55});
        end
        cpu_read(d, none);
        check("R10 overflow frame dropped", none, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_start_and_order();
        t_parity();
        t_tx();
        t_capacity();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule